// File: doc/BRIEF.md
# Power State Request/Confirm Controller

This block keeps track of the device power mode: normal running, sleep or standby. Moving into a low-power mode takes two steps. A request command first raises a pending flag and leaves the mode unchanged. A separate confirm command then carries out the move. While the request waits, the host can see the pending flag in the status byte. It reads that byte back with a NOP or with any other command it sends.

The inputs are single-cycle strobes from the command decoder. The outputs go to the status byte: a two-bit power-state code, a sleep-pending flag and a standby-pending flag. A further output enables the internal oscillator. The oscillator is shut down in either low-power mode and runs again on return to normal.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `pwr_state` is 2'b10 (normal), both pending flags are 0 and `osc_en` is 1.
- R2: In normal mode, a request-sleep strobe sets `sleep_pend` and leaves `pwr_state` at 2'b10.
- R3: A confirm-sleep strobe while `sleep_pend` is 1 clears `sleep_pend`, sets `pwr_state` to 2'b00 (sleep) and drops `osc_en` to 0.
- R4: In normal mode, a request-standby strobe sets `stby_pend`. A later confirm-standby strobe clears it, sets `pwr_state` to 2'b01 (standby) and drops `osc_en` to 0.
- R5: A wake strobe in sleep or standby sets `pwr_state` to 2'b10 and raises `osc_en` to 1.
- R6: A confirm strobe that has no matching pending flag changes no output.
- R7: A request for one low-power mode clears any pending request for the other mode. At most one pending flag is 1 at any time.
- R8: A NOP strobe, or a cycle with no strobe, changes no output, so a pending flag stays readable.
- R9: In sleep or standby, request and confirm strobes are ignored.
- R10: When several strobes arrive in the same cycle, only one takes effect. The order is: wake, confirm-sleep, confirm-standby, request-sleep, request-standby.
- R11: A wake strobe in normal mode clears both pending flags.
- R12: `osc_en` is 1 exactly when `pwr_state` is 2'b10. Every output changes at the first rising clock edge after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_sleep | input | 1 | Request-sleep strobe |
| cfm_sleep | input | 1 | Confirm-sleep strobe |
| req_stby | input | 1 | Request-standby strobe |
| cfm_stby | input | 1 | Confirm-standby strobe |
| wake | input | 1 | Return-to-normal strobe |
| nop | input | 1 | No-operation strobe (status poll) |
| pwr_state | output | 2 | Power-state code: 10 normal, 01 standby, 00 sleep |
| sleep_pend | output | 1 | Sleep request pending |
| stby_pend | output | 1 | Standby request pending |
| osc_en | output | 1 | Internal oscillator enable |

## Verification
Every output is a register, so each result is due at the first rising edge after its strobe. The bench drives each strobe for exactly one cycle, starting at a falling edge. It then samples the outputs at the next falling edge, which is half a period after the edge where they change. Checks that an output holds its value sample again one full cycle later, with no strobe active in between.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sleep,
  input  logic       cfm_sleep,
  input  logic       req_stby,
  input  logic       cfm_stby,
  input  logic       wake,
  input  logic       nop,
  output logic [1:0] pwr_state,
  output logic       sleep_pend,
  output logic       stby_pend,
  output logic       osc_en
);
  localparam logic [1:0] ST_NORM  = 2'b10;
  localparam logic [1:0] ST_STBY  = 2'b01;
  localparam logic [1:0] ST_SLEEP = 2'b00;

  logic in_norm;
  logic idle_poll;
  assign in_norm   = (pwr_state == ST_NORM);
  assign idle_poll = nop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_state  <= ST_NORM;
      sleep_pend <= 1'b0;
      stby_pend  <= 1'b0;
      osc_en     <= 1'b1;
    end else if (wake) begin
      pwr_state  <= ST_NORM;
      sleep_pend <= 1'b0;
      stby_pend  <= 1'b0;
      osc_en     <= 1'b1;
    end else if (in_norm) begin
      if (cfm_sleep && sleep_pend) begin
        pwr_state  <= ST_SLEEP;
        sleep_pend <= 1'b0;
        osc_en     <= 1'b0;
      end else if (cfm_stby && stby_pend) begin
        pwr_state <= ST_STBY;
        stby_pend <= 1'b0;
        osc_en    <= 1'b0;
      end else if (req_sleep) begin
        sleep_pend <= 1'b1;
        stby_pend  <= 1'b0;
      end else if (req_stby) begin
        stby_pend  <= 1'b1;
        sleep_pend <= 1'b0;
      end else if (idle_poll) begin
        sleep_pend <= sleep_pend;
      end
    end
  end
endmodule

module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_sleep,
  input logic       cfm_sleep,
  input logic       req_stby,
  input logic       cfm_stby,
  input logic       wake,
  input logic [1:0] pwr_state,
  input logic       sleep_pend,
  input logic       stby_pend,
  input logic       osc_en
);
  logic any_cmd;
  assign any_cmd = req_sleep | cfm_sleep | req_stby | cfm_stby | wake;

  // R7
  pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_pend, stby_pend}));
  // R12
  osc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en == (pwr_state == 2'b10));
  // R5
  wake_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (pwr_state == 2'b10 && osc_en));
  // R2
  req_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sleep && !wake && !cfm_sleep && !cfm_stby && pwr_state == 2'b10)
      |=> (sleep_pend && pwr_state == 2'b10));
  // R3
  cfm_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfm_sleep && sleep_pend && !wake && pwr_state == 2'b10)
      |=> (pwr_state == 2'b00 && !sleep_pend && !osc_en));
  // R6
  cfm_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfm_sleep && !sleep_pend && !stby_pend && !wake && !req_sleep && !req_stby)
      |=> $stable(pwr_state));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> ($stable(pwr_state) && $stable(sleep_pend) && $stable(stby_pend)));
  // R9
  lowpwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b10 && !wake) |=> ($stable(pwr_state) && !sleep_pend && !stby_pend));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_sleep(req_sleep), .cfm_sleep(cfm_sleep),
  .req_stby(req_stby), .cfm_stby(cfm_stby), .wake(wake),
  .pwr_state(pwr_state), .sleep_pend(sleep_pend), .stby_pend(stby_pend),
  .osc_en(osc_en)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_sleep = 0, cfm_sleep = 0, req_stby = 0, cfm_stby = 0, wake = 0, nop = 0;
  logic [1:0] pwr_state;
  logic sleep_pend, stby_pend, osc_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_sleep(req_sleep), .cfm_sleep(cfm_sleep),
    .req_stby(req_stby), .cfm_stby(cfm_stby), .wake(wake), .nop(nop),
    .pwr_state(pwr_state), .sleep_pend(sleep_pend), .stby_pend(stby_pend),
    .osc_en(osc_en)
  );

  task automatic expect_out(string tag, logic [1:0] st, logic sp, logic tp, logic oe);
    checks++;
    if (pwr_state !== st || sleep_pend !== sp || stby_pend !== tp || osc_en !== oe) begin
      errors++;
      $display("FAIL %s: got st=%b sp=%b tp=%b osc=%b exp st=%b sp=%b tp=%b osc=%b",
               tag, pwr_state, sleep_pend, stby_pend, osc_en, st, sp, tp, oe);
    end
  endtask

  // drive a strobe set for one cycle from a falling edge; return at next falling edge
  task automatic strobe(logic [5:0] v);
    {wake, cfm_sleep, cfm_stby, req_sleep, req_stby, nop} = v;
    @(negedge clk);
    {wake, cfm_sleep, cfm_stby, req_sleep, req_stby, nop} = '0;
  endtask

  localparam logic [5:0] S_WAKE = 6'b100000, S_CSL = 6'b010000, S_CST = 6'b001000,
                         S_RSL = 6'b000100, S_RST = 6'b000010, S_NOP = 6'b000001;

  task automatic go_normal();
    strobe(S_WAKE);
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 2'b10, 0, 0, 1);
  endtask

  task automatic t_sleep_flow();
    go_normal();
    strobe(S_RSL);
    expect_out("R2 req sleep", 2'b10, 1, 0, 1);
    strobe(S_NOP);
    expect_out("R8 nop keeps flag", 2'b10, 1, 0, 1);
    @(negedge clk);
    expect_out("R8 idle keeps flag", 2'b10, 1, 0, 1);
    strobe(S_CSL);
    expect_out("R3 cfm sleep", 2'b00, 0, 0, 0);
    strobe(S_WAKE);
    expect_out("R5 wake from sleep", 2'b10, 0, 0, 1);
  endtask

  task automatic t_stby_flow();
    go_normal();
    strobe(S_RST);
    expect_out("R4 req standby", 2'b10, 0, 1, 1);
    strobe(S_CST);
    expect_out("R4 cfm standby", 2'b01, 0, 0, 0);
    expect_out("R12 osc off in standby", 2'b01, 0, 0, 0);
    strobe(S_WAKE);
    expect_out("R5 wake from standby", 2'b10, 0, 0, 1);
  endtask

  task automatic t_orphan_confirm();
    go_normal();
    strobe(S_CSL);
    expect_out("R6 cfm sleep no pend", 2'b10, 0, 0, 1);
    strobe(S_RST);
    strobe(S_CSL);
    expect_out("R6 cfm sleep with stby pend", 2'b10, 0, 1, 1);
    go_normal();
    strobe(S_RSL);
    strobe(S_CST);
    expect_out("R6 cfm stby with sleep pend", 2'b10, 1, 0, 1);
  endtask

  task automatic t_replace();
    go_normal();
    strobe(S_RSL);
    strobe(S_RST);
    expect_out("R7 stby replaces sleep", 2'b10, 0, 1, 1);
    strobe(S_RSL);
    expect_out("R7 sleep replaces stby", 2'b10, 1, 0, 1);
  endtask

  task automatic t_lowpwr_ignore();
    go_normal();
    strobe(S_RSL);
    strobe(S_CSL);
    strobe(S_RST);
    expect_out("R9 req ignored in sleep", 2'b00, 0, 0, 0);
    strobe(S_CST);
    expect_out("R9 cfm ignored in sleep", 2'b00, 0, 0, 0);
    strobe(S_NOP);
    expect_out("R8 nop in sleep", 2'b00, 0, 0, 0);
  endtask

  task automatic t_priority();
    go_normal();
    strobe(S_RSL);
    strobe(S_CSL | S_RST);
    expect_out("R10 confirm beats request", 2'b00, 0, 0, 0);
    strobe(S_WAKE | S_RSL);
    expect_out("R10 wake beats request", 2'b10, 0, 0, 1);
    strobe(S_RSL | S_RST);
    expect_out("R10 req sleep beats req stby", 2'b10, 1, 0, 1);
  endtask

  task automatic t_cancel();
    go_normal();
    strobe(S_RST);
    strobe(S_WAKE);
    expect_out("R11 wake cancels pending", 2'b10, 0, 0, 1);
  endtask

  task automatic t_timing();
    go_normal();
    strobe(S_RSL);
    {cfm_sleep} = 1'b1;
    @(posedge clk);
    #1;
    expect_out("R12 update at first edge", 2'b00, 0, 0, 0);
    @(negedge clk);
    cfm_sleep = 1'b0;
    go_normal();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sleep_flow();
    t_stby_flow();
    t_orphan_confirm();
    t_replace();
    t_lowpwr_ignore();
    t_priority();
    t_cancel();
    t_timing();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule